// File: doc/BRIEF.md
# Dual-Current Charge Pump Mode Controller

This block decides which of two charge pump current paths a synthesizer loop uses. A frequency change is announced by a one-cycle start strobe, which arms the high-current path. A rising edge on the lock indication then hands control back to the low-current path. The high-current path is allowed only while the delay code taken from the chosen delay register is non-zero. That code also sets how far each phase-detector pulse is widened while the high-current path is active.

Two select bits pass straight through, each behind one register. One picks the high-current magnitude and the other picks the low-current magnitude.

Each delay code stands for a whole number of cycles of the timing clock. Pump enables move only on phase-detector cycle boundaries, which come once every `PD_DIV` clock cycles after reset. This keeps a pump from being switched partway through a pulse.

Top module: `cp_dual_pump_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `hc_pump_en`=0, `lc_pump_en`=1, `pd_stretch`=0, `hc_2ma_sel`=0 and `lc_100ua_sel`=0.
- R2: A `chg_start` strobe arms high-current mode. From the next phase-detector boundary, `hc_pump_en`=1 and `lc_pump_en`=0, provided the active delay code is non-zero.
- R3: A rising edge of `lock_in` with no strobe in the same cycle disarms high-current mode. The next boundary gives `hc_pump_en`=0 and `lc_pump_en`=1.
- R4: A strobe re-arms high-current mode even while `lock_in` is held high. A strobe wins over a lock edge in the same cycle.
- R5: Exactly one of `hc_pump_en` and `lc_pump_en` is high in every cycle after reset.
- R6: The pump enables change only at clock edges whose number since reset release is a multiple of `PD_DIV`. Edges are counted from 1.
- R7: `dly_sel`=0 makes `dly_reg0` the active delay code, and `dly_sel`=1 makes `dly_reg1` the active one.
- R8: An active delay code of 0 keeps `hc_pump_en`=0 and `lc_pump_en`=1, both during a change and after lock.
- R9: `hc_2ma_sel` equals `hc_2ma_bit` one cycle later. The value 0 means 1 mA and 1 means 2 mA.
- R10: `lc_100ua_sel` equals `lc_100ua_bit` one cycle later. The value 0 means 50 uA and 1 means 100 uA.
- R11: `pd_stretch` follows `pd_pulse` one cycle later. While `hc_pump_en`=1 at the last pulse cycle, it stays high for a further N cycles, where N is the active code (01=1, 10=2, 11=3). Otherwise no extra cycles are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | timing clock |
| rst | input | 1 | synchronous active-high reset |
| chg_start | input | 1 | one-cycle frequency-change strobe |
| lock_in | input | 1 | loop lock indication |
| pd_pulse | input | 1 | raw phase-detector pulse |
| hc_2ma_bit | input | 1 | high-current magnitude field |
| lc_100ua_bit | input | 1 | low-current magnitude field |
| dly_sel | input | 1 | delay register select |
| dly_reg0 | input | DLY_W | first delay register |
| dly_reg1 | input | DLY_W | second delay register |
| hc_pump_en | output | 1 | high-current pump enable |
| lc_pump_en | output | 1 | low-current pump enable |
| hc_2ma_sel | output | 1 | high-current magnitude select |
| lc_100ua_sel | output | 1 | low-current magnitude select |
| pd_stretch | output | 1 | widened phase-detector pulse |

## Verification
The bench re-arms with a strobe while lock is held high. A design that lets lock level override the strobe would stay in low-current mode there. It also switches codes between boundaries and checks that every enable change lands on a boundary edge; a design that updates enables freely would cut pulses short. Both registers are set to zero to confirm the high-current path never turns on. The bench then steers the select bit between a zero and a non-zero register, which catches an inverted register mux. Pulse widths are counted with and without high-current mode, which exposes a wrong code-to-cycle mapping or a widening left on after lock.

// File: rtl/cp_ctrl_pkg.sv
package cp_ctrl_pkg;
  localparam int unsigned DLY_W_DEF = 2;

  typedef enum logic [1:0] {
    DLY_OFF = 2'd0,
    DLY_ONE = 2'd1,
    DLY_TWO = 2'd2,
    DLY_THR = 2'd3
  } dly_code_e;

  // A delay code is a count of timing-clock cycles; zero means no high-current path.
  function automatic logic code_enables_hc(input logic [DLY_W_DEF-1:0] code);
    return code != DLY_OFF;
  endfunction
endpackage

// File: rtl/cp_pd_tick.sv
module cp_pd_tick #(
  parameter int PD_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PD_DIV > 2) ? $clog2(PD_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PD_DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/cp_mode_ctrl.sv
module cp_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic chg_start,
  input  logic lock_in,
  input  logic code_nz,
  output logic hc_en,
  output logic lc_en
);
  logic lock_q;
  logic hc_req;
  logic lock_rise;

  assign lock_rise = lock_in & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      hc_req <= 1'b0;
    end else begin
      lock_q <= lock_in;
      if (chg_start) hc_req <= 1'b1;
      else if (lock_rise) hc_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_en <= 1'b0;
      lc_en <= 1'b1;
    end else if (tick) begin
      hc_en <= hc_req & code_nz;
      lc_en <= ~(hc_req & code_nz);
    end
  end

  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    chg_start |=> hc_req);
  assert_lock_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_rise && !chg_start) |=> !hc_req);
  assert_rearm_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (chg_start && lock_in) |=> hc_req);
  assert_one_pump_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot({hc_en, lc_en}));
  assert_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(hc_en) && $stable(lc_en)));
endmodule

// File: rtl/cp_pulse_widen.sv
module cp_pulse_widen #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_pulse,
  input  logic [CNT_W-1:0] width,
  output logic             stretch
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      stretch <= 1'b0;
    end else begin
      stretch <= pd_pulse | (rem_q != '0);
      if (pd_pulse) rem_q <= width;
      else if (rem_q != '0) rem_q <= rem_q - 1'b1;
    end
  end

  assert_follow_R11: assert property (@(posedge clk) disable iff (rst)
    pd_pulse |=> stretch);
  assert_tail_R11: assert property (@(posedge clk) disable iff (rst)
    (!pd_pulse && rem_q == '0) |=> !stretch);
endmodule

// File: rtl/cp_dual_pump_ctrl.sv
module cp_dual_pump_ctrl #(
  parameter int PD_DIV = 8,
  parameter int DLY_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chg_start,
  input  logic             lock_in,
  input  logic             pd_pulse,
  input  logic             hc_2ma_bit,
  input  logic             lc_100ua_bit,
  input  logic             dly_sel,
  input  logic [DLY_W-1:0] dly_reg0,
  input  logic [DLY_W-1:0] dly_reg1,
  output logic             hc_pump_en,
  output logic             lc_pump_en,
  output logic             hc_2ma_sel,
  output logic             lc_100ua_sel,
  output logic             pd_stretch
);
  logic             tick;
  logic [DLY_W-1:0] act_code;
  logic [DLY_W-1:0] widen;
  logic             code_nz;

  assign act_code = dly_sel ? dly_reg1 : dly_reg0;
  assign code_nz  = (act_code != '0);
  assign widen    = hc_pump_en ? act_code : '0;

  cp_pd_tick #(.PD_DIV(PD_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cp_mode_ctrl u_mode (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .chg_start (chg_start),
    .lock_in   (lock_in),
    .code_nz   (code_nz),
    .hc_en     (hc_pump_en),
    .lc_en     (lc_pump_en)
  );

  cp_pulse_widen #(.CNT_W(DLY_W)) u_widen (
    .clk      (clk),
    .rst      (rst),
    .pd_pulse (pd_pulse),
    .width    (widen),
    .stretch  (pd_stretch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_2ma_sel   <= 1'b0;
      lc_100ua_sel <= 1'b0;
    end else begin
      hc_2ma_sel   <= hc_2ma_bit;
      lc_100ua_sel <= lc_100ua_bit;
    end
  end

  assert_zero_code_off_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && act_code == '0) |=> (!hc_pump_en && lc_pump_en));
  assert_hc_level_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hc_2ma_sel == $past(hc_2ma_bit)));
  assert_lc_level_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lc_100ua_sel == $past(lc_100ua_bit)));
  assert_sel_reg1_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && dly_sel && dly_reg1 == '0) |=> !hc_pump_en);
endmodule

// File: tb/tb_cp_dual_pump_ctrl.sv
module tb_cp_dual_pump_ctrl;
  localparam int PD = 8;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg_start = 0, lock_in = 0, pd_pulse = 0;
  logic hc_2ma_bit = 0, lc_100ua_bit = 0, dly_sel = 0;
  logic [DW-1:0] dly_reg0 = '0, dly_reg1 = '0;
  logic hc_pump_en, lc_pump_en, hc_2ma_sel, lc_100ua_sel, pd_stretch;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cp_dual_pump_ctrl #(.PD_DIV(PD), .DLY_W(DW)) dut (.*);

  // reference model built from the requirements
  logic m_lockq, m_req, m_hc, m_lc, m_h2, m_l1, m_str;
  logic [DW-1:0] m_cnt;
  int ecount;

  function automatic logic [DW-1:0] pick_code(logic s, logic [DW-1:0] a, logic [DW-1:0] b);
    return s ? b : a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lockq <= 0; m_req <= 0; m_hc <= 0; m_lc <= 1;
      m_h2 <= 0; m_l1 <= 0; m_str <= 0; m_cnt <= '0; ecount <= 0;
    end else begin
      logic [DW-1:0] c;
      c = pick_code(dly_sel, dly_reg0, dly_reg1);
      ecount <= ecount + 1;
      m_lockq <= lock_in;
      if (chg_start) m_req <= 1;
      else if (lock_in && !m_lockq) m_req <= 0;
      if ((ecount + 1) % PD == 0) begin
        m_hc <= m_req && (c != 0);
        m_lc <= !(m_req && (c != 0));
      end
      m_h2 <= hc_2ma_bit;
      m_l1 <= lc_100ua_bit;
      m_str <= pd_pulse || (m_cnt != 0);
      if (pd_pulse) m_cnt <= m_hc ? c : '0;
      else if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic prev_hc = 0;
  logic run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk("R2", hc_pump_en, m_hc);
      chk("R5", lc_pump_en, m_lc);
      chk("R9", hc_2ma_sel, m_h2);
      chk("R10", lc_100ua_sel, m_l1);
      chk("R11", pd_stretch, m_str);
      if (hc_pump_en != prev_hc) chk("R6", ecount % PD, 0);
    end
    prev_hc = hc_pump_en;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    chg_start = 1; cyc(1); chg_start = 0;
  endtask

  task automatic pulse_len(input string req, input int exp);
    int hi;
    hi = 0;
    pd_pulse = 1; cyc(1); pd_pulse = 0;
    for (int i = 0; i < 8; i++) begin
      if (pd_stretch) hi++;
      cyc(1);
    end
    chk(req, hi, exp);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    // R1 reset state while reset held
    chk("R1", {hc_pump_en, lc_pump_en, pd_stretch, hc_2ma_sel, lc_100ua_sel}, 5'b01000);
    rst = 0;
    cyc(1);
    chk("R1", {hc_pump_en, lc_pump_en, pd_stretch}, 3'b010);
    run_cmp = 1;

    // R7: register 1 chosen, non-zero
    dly_reg0 = 2'd0; dly_reg1 = 2'd2; dly_sel = 1;
    strobe(); cyc(PD + 1);
    chk("R7", hc_pump_en, 1);
    chk("R2", lc_pump_en, 0);
    pulse_len("R11", 3);
    // R7: switch to register 0 which holds zero
    dly_sel = 0; cyc(PD + 1);
    chk("R7", hc_pump_en, 0);
    pulse_len("R11", 1);
    dly_sel = 1; dly_reg1 = 2'd3; cyc(PD + 1);
    pulse_len("R11", 4);
    dly_reg1 = 2'd1; cyc(1);
    pulse_len("R11", 2);

    // R3: lock edge hands back to low current
    lock_in = 1; cyc(PD + 1);
    chk("R3", {hc_pump_en, lc_pump_en}, 2'b01);
    pulse_len("R11", 1);

    // R4: strobe while locked re-arms
    strobe(); cyc(PD + 1);
    chk("R4", hc_pump_en, 1);

    // R4: strobe and lock rise together, strobe wins
    lock_in = 0; cyc(1);
    lock_in = 1; chg_start = 1; cyc(1); chg_start = 0; cyc(PD + 1);
    chk("R4", hc_pump_en, 1);
    lock_in = 0; cyc(1); lock_in = 1; cyc(PD + 1);
    chk("R3", hc_pump_en, 0);

    // R8: both registers zero
    lock_in = 0; dly_reg0 = 0; dly_reg1 = 0;
    strobe(); cyc(PD + 1);
    chk("R8", {hc_pump_en, lc_pump_en}, 2'b01);
    dly_sel = 0; cyc(PD + 1);
    chk("R8", {hc_pump_en, lc_pump_en}, 2'b01);
    lock_in = 1; cyc(PD + 1);
    chk("R8", hc_pump_en, 0);

    // R9 / R10 level selects
    hc_2ma_bit = 1; lc_100ua_bit = 0; cyc(1);
    chk("R9", hc_2ma_sel, 1);
    chk("R10", lc_100ua_sel, 0);
    hc_2ma_bit = 0; lc_100ua_bit = 1; cyc(1);
    chk("R9", hc_2ma_sel, 0);
    chk("R10", lc_100ua_sel, 1);

    // constrained random phase, compared per cycle against the model
    for (int i = 0; i < 4000; i++) begin
      chg_start    = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 11) == 0) lock_in = ~lock_in;
      pd_pulse     = ($urandom_range(0, 3) == 0);
      hc_2ma_bit   = $urandom_range(0, 1);
      lc_100ua_bit = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) begin
        dly_sel  = $urandom_range(0, 1);
        dly_reg0 = DW'($urandom_range(0, 3));
        dly_reg1 = DW'($urandom_range(0, 3));
      end
      cyc(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule